// File: doc/BRIEF.md
# Four-Pin GPIO Port with Input Polarity and Change Interrupt

This block is a small general-purpose I/O port of four pins behind a simple register bus. Each pin carries a direction bit, an output latch bit and an input polarity bit. Software reads the synchronised pin levels through a read-only input register, optionally inverted per bit. The block raises an active-low interrupt whenever an input pin moves away from the level captured at the last read of the input register.

The interrupt compares the synchronised pins with a snapshot of their levels. The snapshot is reloaded on every read of the input register, and at reset it takes the current pin levels. The interrupt is released by that read, or by the pin returning to its snapshot level. Pins configured as outputs do not take part in the comparison. Switching a pin from output to input can therefore raise the interrupt at once, and the block does not hide this.

All state uses a synchronous, active-high reset. Read data is registered and appears one cycle after the read strobe.

Top module: `gpio_pol_port`

## Requirements
- R1: Register 3 (address 2'b11) is the direction register. Bit n = 1 makes pin n an input (pin_oe[n] low) and bit n = 0 makes it an output (pin_oe[n] high). Its low four bits reset to 1, so the register reads 8'hFF after reset.
- R2: Register 1 (address 2'b01) is the output latch. It resets to 8'hFF and pin_out follows its low four bits from the cycle after a write. A read returns the latch contents, not the level on the pin.
- R3: Register 2 (address 2'b10) is the polarity register and resets to 8'h00. When bit n is set, bit n of the input register reads inverted. When bit n is clear, bit n reads as the pin level.
- R4: Register 0 (address 2'b00) is read-only and writes to it are ignored. Its low four bits give the level of every pin after a two-flop synchroniser, for input pins and output pins alike.
- R5: Bits 7..4 read as 1 in registers 0, 1 and 3, and as 0 in register 2, whatever value was written.
- R6: irq_n goes low when a pin whose direction bit is 1 differs from its snapshot bit. This happens on the third rising edge after the pin changes. Pins whose direction bit is 0 never assert irq_n.
- R7: A read of register 0 reloads the snapshot from the synchronised pins and releases irq_n at the same clock edge that registers the read data.
- R8: If an input pin returns to its snapshot level and no other input pin differs, irq_n is released without any read.
- R9: When a pin whose level differs from its snapshot bit is switched from output to input, irq_n asserts.
- R10: Reset restores every register to its default, which turns all pins into inputs. It loads the snapshot with the current pin levels and holds irq_n high, so no interrupt follows reset.
- R11: rdata changes only on the clock edge that samples rd_en. It holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pin_in | input | 4 | Level seen on each pin |
| pin_out | output | 4 | Output latch value driven to the pins |
| pin_oe | output | 4 | Per-pin driver enable, high for output pins |
| irq_n | output | 1 | Active-low interrupt, modelled as the open-drain pull-down |

## Verification
The bench models each pad as the block's own output when pin_oe is high and as an external level otherwise. This lets readback separate the output latch from the true pin level. Input patterns with and without inversion show that the polarity bits act only on the input register and never on the interrupt comparison. Interrupt stimulus is run three ways: a pin that changes and then returns, a pin that changes and is then read, and a pin that changes while it is an output. These show the difference between release by return, release by read, and masking by direction. A final pattern parks a mismatching output pin and then turns it into an input, which must raise the interrupt.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_DRIVE = 2'd1,
    SEL_INVERT = 2'd2,
    SEL_DIR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_ff @(posedge clk) stg[i] <= stg[i-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int N = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  pin_lvl,
  output logic [DW-1:0] rdata,
  output logic [N-1:0]  dir_q,
  output logic [N-1:0]  drv_q,
  output logic [N-1:0]  inv_q
);
  localparam logic [DW-1:0] HI_ONES = {DW{1'b1}} << N;

  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      drv_q <= '1;
      inv_q <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(addr))
        SEL_DRIVE:  drv_q <= wdata[N-1:0];
        SEL_INVERT: inv_q <= wdata[N-1:0];
        SEL_DIR:    dir_q <= wdata[N-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(addr))
      SEL_LEVEL:  rd_mux = HI_ONES | DW'(pin_lvl ^ inv_q);
      SEL_DRIVE:  rd_mux = HI_ONES | DW'(drv_q);
      SEL_INVERT: rd_mux = DW'(inv_q);
      default:    rd_mux = HI_ONES | DW'(dir_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_lvl,
  input  logic [N-1:0] dir_q,
  input  logic         snap_ld,
  output logic         irq_n
);
  logic [N-1:0] snap_q;
  logic         differs;

  assign differs = |((pin_lvl ^ snap_q) & dir_q);

  always_ff @(posedge clk) begin
    if (rst || snap_ld) snap_q <= pin_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst || snap_ld) irq_n <= 1'b1;
    else                irq_n <= ~differs;
  end
endmodule

// File: rtl/gpio_pol_port.sv
module gpio_pol_port
  import gpio_pkg::*;
#(
  parameter int NPIN = 4,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq_n
);
  logic [NPIN-1:0] pin_lvl;
  logic [NPIN-1:0] dir_q, drv_q, inv_q;
  logic            snap_ld;

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .d(pin_in), .q(pin_lvl)
  );

  gpio_regs #(.N(NPIN), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .pin_lvl(pin_lvl), .rdata(rdata),
    .dir_q(dir_q), .drv_q(drv_q), .inv_q(inv_q)
  );

  assign snap_ld = rd_en && (reg_sel_e'(addr) == SEL_LEVEL);

  gpio_irq #(.N(NPIN)) u_irq (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .dir_q(dir_q),
    .snap_ld(snap_ld), .irq_n(irq_n)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = drv_q;
endmodule

// File: rtl/gpio_pol_port_chk.sv
module gpio_pol_port_chk #(
  parameter int NPIN = 4,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      addr,
  input logic            wr_en,
  input logic            rd_en,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq_n
);
  AST_RST_ALL_INPUTS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_oe == '0 && irq_n)); // R10
  AST_DIR_SETS_OE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd3) |=> (pin_oe == ~$past(wdata[NPIN-1:0]))); // R1
  AST_DRIVE_TO_PIN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd1) |=> (pin_out == $past(wdata[NPIN-1:0]))); // R2
  AST_INVERT_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd2) |=> (rdata[DW-1:NPIN] == '0)); // R5
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd0) |=> irq_n); // R7
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !$past(rst)) |=> $stable(rdata)); // R11
endmodule

bind gpio_pol_port gpio_pol_port_chk #(.NPIN(NPIN), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_n(irq_n)
);

// File: tb/sim_gpio_pol_port.sv
`timescale 1ns/1ps
module sim_gpio_pol_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] ext = 4'b1010;
  logic [3:0] pin_out, pin_oe, pads;
  logic       irq_n;
  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb_q[$];
  logic rd_seen = 1'b0;

  always #2 clk = ~clk;

  for (genvar i = 0; i < 4; i++) begin : g_pad
    assign pads[i] = pin_oe[i] ? pin_out[i] : ext[i];
  end

  gpio_pol_port u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pin_in(pads), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each registered read result against the scoreboard
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, rdata, e.exp);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    addr = a; rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(1);
    // reset state
    check("R10 irq_n after reset", {7'd0, irq_n}, 8'd1);
    check("R1 pin_oe after reset", {4'd0, pin_oe}, 8'h00);
    rd(2'd3, 8'hFF, "R1 dir reset");
    rd(2'd1, 8'hFF, "R2 drive reset");
    rd(2'd2, 8'h00, "R3 invert reset");
    rd(2'd0, 8'hFA, "R4 level after reset");
    tick(1);
    // R11: rdata holds without a read
    check("R11 rdata held", rdata, 8'hFA);
    // polarity, upper bits
    wr(2'd2, 8'hF5);
    rd(2'd2, 8'h05, "R5 invert upper bits zero");
    rd(2'd0, 8'hFF, "R3 inverted level");
    // write to level register ignored
    wr(2'd0, 8'h00);
    rd(2'd0, 8'hFF, "R4 write ignored");
    wr(2'd2, 8'h00);
    // outputs: pins 0,1 outputs, latch 3
    wr(2'd1, 8'h03);
    wr(2'd3, 8'h0C);
    check("R1 pin_oe outputs", {4'd0, pin_oe}, 8'h03);
    check("R2 pin_out", {4'd0, pin_out}, 8'h03);
    tick(3);
    check("R6 output pin masked", {7'd0, irq_n}, 8'd1);
    rd(2'd1, 8'hF3, "R2 drive readback");
    rd(2'd0, 8'hFB, "R4 level sees output pins");
    rd(2'd3, 8'hFC, "R5 dir upper ones");
    // R9: pin0 snapshot 1, external 0; switch back to input
    wr(2'd3, 8'hFF);
    tick(1);
    check("R9 not yet", {7'd0, irq_n}, 8'd1);
    tick(3);
    check("R9 false irq on dir change", {7'd0, irq_n}, 8'd0);
    rd(2'd0, 8'hFA, "R4 level after dir change");
    check("R7 read releases", {7'd0, irq_n}, 8'd1);
    tick(3);
    check("R7 stays released", {7'd0, irq_n}, 8'd1);
    // R6/R8: change and return
    ext = 4'b0010;
    tick(2);
    check("R6 latency not yet", {7'd0, irq_n}, 8'd1);
    tick(1);
    check("R6 change asserts", {7'd0, irq_n}, 8'd0);
    ext = 4'b1010;
    tick(4);
    check("R8 return releases", {7'd0, irq_n}, 8'd1);
    // polarity does not disturb the comparison
    wr(2'd2, 8'h0F);
    tick(3);
    check("R6 invert no irq", {7'd0, irq_n}, 8'd1);
    ext = 4'b1011;
    tick(4);
    check("R6 change with invert", {7'd0, irq_n}, 8'd0);
    rd(2'd0, 8'hF4, "R3 inverted new level");
    check("R7 read clears", {7'd0, irq_n}, 8'd1);
    tick(4);
    check("R7 new snapshot holds", {7'd0, irq_n}, 8'd1);
    // reset mid-run
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h00);
    ext = 4'b0100;
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(1);
    check("R10 oe cleared", {4'd0, pin_oe}, 8'h00);
    rd(2'd3, 8'hFF, "R10 dir default");
    rd(2'd1, 8'hFF, "R10 drive default");
    rd(2'd2, 8'h00, "R10 invert default");
    tick(3);
    check("R10 no irq after reset", {7'd0, irq_n}, 8'd1);
    tick(2);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule